// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block is the front end that sequences instructions in a small 8-bit controller core. It divides the system clock into four phase strobes, T1 to T4, that together form one instruction cycle. It keeps the program counter and the instruction register. The fetch of the next instruction runs during the same cycle as the execution of the current one, so straight-line code completes one instruction per instruction cycle.

The program counter moves to its next value when T1 begins, and the program word at that address is captured during T1. At the next T1 boundary that word becomes the executing instruction. Two requests can change the flow. The first is a jump or call request that carries a full target address. The second is a direct write of the low byte of the counter. Either request is taken only at the end of T4 of a valid executing instruction. When one is taken, the word already fetched is discarded, and the instruction-valid flag stays low for one instruction cycle while the new address is fetched.

A T1-aligned sync output runs at a quarter of the clock rate. External logic can use it to align itself with the instruction cycle.

Top module: `iseq_top`

## Requirements
- R1: `phase_o` is one-hot. Bit 0 marks T1 and bit 3 marks T4. It advances one bit per clock in the order T1, T2, T3, T4, T1. Reset puts it at T1.
- R2: `sync_o` is high in T1 and low in T2, T3 and T4. This gives a 1:3 high/low waveform at a quarter of the clock rate.
- R3: After reset `imem_addr` is 0 and `insn_valid_o` is low for the first instruction cycle. In the second cycle the executing instruction is the word read from address 0.
- R4: With no change of flow, `imem_addr` increases by one at each T1 boundary and holds steady through all four phases. The value 2^PC_W-1 wraps to 0.
- R5: The word on `imem_rdata` during T1 of one instruction cycle appears on `insn_o`, with `insn_valid_o` high, for all four phases of the next cycle.
- R6: A jump request that is high at the end of T4 while `insn_valid_o` is high loads `jmp_target` into the address at the next T1. That cycle has `insn_valid_o` low. The target word executes in the cycle after.
- R7: A low-byte write that is taken at the end of T4 (while `insn_valid_o` is high) replaces address bits 7:0 with `pcl_wdata` and keeps the upper bits. It costs one bubble cycle in the same way as R6.
- R8: If a jump request and a low-byte write are both present, the jump is taken and the write is dropped.
- R9: Requests that are present in T1, T2 or T3, or at the end of T4 of a bubble cycle, have no effect. The address steps by one and the next cycle is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_rdata | input | INSN_W | Program memory read data for `imem_addr` |
| jmp_req | input | 1 | Jump/call request from the executing instruction |
| jmp_target | input | PC_W | Full jump/call target address |
| pcl_we | input | 1 | Write strobe for the counter low byte |
| pcl_wdata | input | PCL_W | New low byte of the counter |
| imem_addr | output | PC_W | Program memory fetch address |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = T1 |
| sync_o | output | 1 | T1 sync, one clock high in four |
| insn_o | output | INSN_W | Executing instruction |
| insn_valid_o | output | 1 | High when `insn_o` is a real instruction |

## Verification
The first pattern is straight-line runs, including one that crosses the top of the address space. These separate a correct increment-and-wrap from an address that stalls or skips. Directed jumps, low-byte writes and cases with both requests together check that each redirect lands on the right address, that it costs exactly one bubble, and that the jump has priority. Requests raised during a bubble, and random noise driven in T1 to T3, separate sampling at the T4 boundary only from sampling in every phase. A seeded random tail mixes all of these cases back to back, so a bubble can fall directly after another redirect.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
   localparam int unsigned NUM_PHASES = 4;

   typedef enum logic [1:0] {
      PH_T1 = 2'd0,
      PH_T2 = 2'd1,
      PH_T3 = 2'd2,
      PH_T4 = 2'd3
   } phase_e;

   // variants of the phase generator
   localparam int unsigned PHG_BINARY = 0;
   localparam int unsigned PHG_RING   = 1;
endpackage

// File: rtl/iseq_phase_gen.sv
module iseq_phase_gen
   import iseq_pkg::*;
#(
   parameter int unsigned IMPL = PHG_RING
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic [NUM_PHASES-1:0] strb_o,
   output logic                  sync_o
);
   generate
      if (IMPL == PHG_BINARY) begin : g_binary
         phase_e cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= PH_T1;
            else        cnt_q <= phase_e'(cnt_q + 2'd1);
         end
         always_comb begin
            strb_o = '0;
            strb_o[cnt_q] = 1'b1;
         end
         assign sync_o = (cnt_q == PH_T1);
      end else if (IMPL == PHG_RING) begin : g_ring
         logic [NUM_PHASES-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q <= NUM_PHASES'(1);
            else        ring_q <= {ring_q[NUM_PHASES-2:0], ring_q[NUM_PHASES-1]};
         end
         assign strb_o = ring_q;
         assign sync_o = ring_q[0];
      end else begin : g_bad
         $error("iseq_phase_gen: unknown IMPL value");
      end
   endgenerate
endmodule

// File: rtl/iseq_pc.sv
module iseq_pc #(
   parameter int unsigned PC_W  = 11,
   parameter int unsigned PCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             jmp_i,
   input  logic [PC_W-1:0]  jmp_tgt_i,
   input  logic             pcl_i,
   input  logic [PCL_W-1:0] pcl_data_i,
   output logic [PC_W-1:0]  pc_o
);
   localparam int unsigned HI_W = PC_W - PCL_W;

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_low_wr;

   generate
      if (HI_W > 0) begin : g_hi
         assign pc_low_wr = {pc_q[PC_W-1:PCL_W], pcl_data_i};
      end else begin : g_nohi
         assign pc_low_wr = pcl_data_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (step_i) begin
         if (jmp_i)      pc_q <= jmp_tgt_i;
         else if (pcl_i) pc_q <= pc_low_wr;
         else            pc_q <= pc_q + PC_W'(1);
      end
   end

   assign pc_o = pc_q;
endmodule

// File: rtl/iseq_fetch.sv
module iseq_fetch #(
   parameter int unsigned INSN_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              step_i,
   input  logic              flush_i,
   input  logic [INSN_W-1:0] rdata_i,
   output logic [INSN_W-1:0] ir_o,
   output logic              valid_o
);
   logic [INSN_W-1:0] fbuf_q;
   logic [INSN_W-1:0] ir_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fbuf_q <= '0;
      else if (capture_i) fbuf_q <= rdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q    <= '0;
         valid_q <= 1'b0;
      end else if (step_i) begin
         ir_q    <= fbuf_q;
         valid_q <= ~flush_i;
      end
   end

   assign ir_o    = ir_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/iseq_top.sv
module iseq_top
   import iseq_pkg::*;
#(
   parameter int unsigned PC_W     = 11,
   parameter int unsigned PCL_W    = 8,
   parameter int unsigned INSN_W   = 14,
   parameter int unsigned PHG_IMPL = PHG_RING
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] imem_rdata,
   input  logic              jmp_req,
   input  logic [PC_W-1:0]   jmp_target,
   input  logic              pcl_we,
   input  logic [PCL_W-1:0]  pcl_wdata,
   output logic [PC_W-1:0]   imem_addr,
   output logic [3:0]        phase_o,
   output logic              sync_o,
   output logic [INSN_W-1:0] insn_o,
   output logic              insn_valid_o
);
   generate
      if (PC_W < PCL_W || PC_W > 16) begin : g_chk_pc
         $error("iseq_top: PC_W must lie between PCL_W and 16");
      end
      if (PCL_W < 1) begin : g_chk_pcl
         $error("iseq_top: PCL_W must be at least 1");
      end
      if (INSN_W < 1) begin : g_chk_insn
         $error("iseq_top: INSN_W must be at least 1");
      end
   endgenerate

   logic [NUM_PHASES-1:0] strb;
   logic                  phg_sync;
   logic                  end_t1, end_t4;
   logic                  accept, take_jmp, take_pcl, flush;
   logic                  valid;

   iseq_phase_gen #(.IMPL(PHG_IMPL)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb_o (strb),
      .sync_o (phg_sync)
   );

   assign end_t1 = strb[PH_T1];
   assign end_t4 = strb[PH_T4];

   // only a real instruction may redirect; the jump outranks the low-byte write
   assign accept   = end_t4 & valid;
   assign take_jmp = accept & jmp_req;
   assign take_pcl = accept & pcl_we & ~jmp_req;
   assign flush    = take_jmp | take_pcl;

   iseq_pc #(.PC_W(PC_W), .PCL_W(PCL_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (end_t4),
      .jmp_i      (take_jmp),
      .jmp_tgt_i  (jmp_target),
      .pcl_i      (take_pcl),
      .pcl_data_i (pcl_wdata),
      .pc_o       (imem_addr)
   );

   iseq_fetch #(.INSN_W(INSN_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (end_t1),
      .step_i    (end_t4),
      .flush_i   (flush),
      .rdata_i   (imem_rdata),
      .ir_o      (insn_o),
      .valid_o   (valid)
   );

   assign phase_o      = strb;
   assign sync_o       = phg_sync;
   assign insn_valid_o = valid;
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk #(
   parameter int unsigned PC_W   = 11,
   parameter int unsigned PCL_W  = 8,
   parameter int unsigned INSN_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        phase_o,
   input logic              sync_o,
   input logic [PC_W-1:0]   imem_addr,
   input logic [INSN_W-1:0] insn_o,
   input logic              insn_valid_o,
   input logic              jmp_req,
   input logic [PC_W-1:0]   jmp_target,
   input logic              pcl_we,
   input logic [PCL_W-1:0]  pcl_wdata
);
   // R1
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_o) == 1);

   // R1
   phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_o == {$past(phase_o[2:0]), $past(phase_o[3])});

   // R2
   sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o == phase_o[0]);

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_o[3] |=> $stable(imem_addr));

   // R5
   insn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_o[3] |=> $stable(insn_o) && $stable(insn_valid_o));

   // R4
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o[3] && !jmp_req && !pcl_we |=>
         insn_valid_o && imem_addr == PC_W'($past(imem_addr) + PC_W'(1)));

   // R6
   jump_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o[3] && insn_valid_o && jmp_req |=>
         !insn_valid_o && imem_addr == $past(jmp_target));

   // R7
   pcl_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o[3] && insn_valid_o && pcl_we && !jmp_req |=>
         !insn_valid_o && imem_addr[PCL_W-1:0] == $past(pcl_wdata));

   // R9
   bubble_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o[3] && !insn_valid_o |=>
         insn_valid_o && imem_addr == PC_W'($past(imem_addr) + PC_W'(1)));
endmodule

bind iseq_top iseq_chk #(.PC_W(PC_W), .PCL_W(PCL_W), .INSN_W(INSN_W)) u_chk (.*);

// File: tb/iseq_top_bench.sv
module iseq_top_bench;
   localparam int unsigned PC_W   = 11;
   localparam int unsigned PCL_W  = 8;
   localparam int unsigned INSN_W = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [INSN_W-1:0] imem_rdata;
   logic              jmp_req = 1'b0;
   logic [PC_W-1:0]   jmp_target = '0;
   logic              pcl_we = 1'b0;
   logic [PCL_W-1:0]  pcl_wdata = '0;
   logic [PC_W-1:0]   imem_addr;
   logic [3:0]        phase_o;
   logic              sync_o;
   logic [INSN_W-1:0] insn_o;
   logic              insn_valid_o;

   int n_vec = 0;
   int n_bad = 0;

   // model state
   logic [PC_W-1:0]   m_pc;
   logic [INSN_W-1:0] m_ir;
   logic              m_valid;
   string             m_tag;

   always #10 clk = ~clk;   // 50 MHz

   function automatic logic [INSN_W-1:0] mem_word(input logic [PC_W-1:0] a);
      logic [INSN_W-1:0] w;
      w = INSN_W'(a);
      return (w * 14'd7) ^ (w << 5) ^ 14'h2A5;
   endfunction

   assign imem_rdata = mem_word(imem_addr);

   iseq_top u_iseq_top (
      .clk(clk), .rst_n(rst_n), .imem_rdata(imem_rdata),
      .jmp_req(jmp_req), .jmp_target(jmp_target),
      .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
      .imem_addr(imem_addr), .phase_o(phase_o), .sync_o(sync_o),
      .insn_o(insn_o), .insn_valid_o(insn_valid_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // one instruction cycle; requests are held at the end of T4, noise elsewhere
   task automatic run_cycle(input bit jr, input logic [PC_W-1:0] tgt,
                            input bit we, input logic [PCL_W-1:0] d, input bit noise);
      logic [INSN_W-1:0] fetched;
      bit tj, tp;
      for (int p = 0; p < 4; p++) begin
         chk(phase_o == 4'(1 << p), "R1", "phase strobe", phase_o, 1 << p);
         chk(sync_o == (p == 0), "R2", "sync", sync_o, p == 0);
         chk(imem_addr == m_pc, m_tag, "fetch address", imem_addr, m_pc);
         chk(insn_valid_o == m_valid, m_tag, "valid flag", insn_valid_o, m_valid);
         if (m_valid)
            chk(insn_o == m_ir, "R5", "executing word", insn_o, m_ir);
         if (p < 3) begin
            jmp_req    = noise ? 1'($urandom) : 1'b0;
            pcl_we     = noise ? 1'($urandom) : 1'b0;
            jmp_target = PC_W'($urandom);
            pcl_wdata  = PCL_W'($urandom);
         end else begin
            jmp_req    = jr;
            jmp_target = tgt;
            pcl_we     = we;
            pcl_wdata  = d;
         end
         @(negedge clk);
      end
      // model of the T4 -> T1 boundary
      fetched = mem_word(m_pc);
      tj = m_valid && jr;
      tp = m_valid && we && !jr;
      if (tj)      m_pc = tgt;
      else if (tp) m_pc = {m_pc[PC_W-1:PCL_W], d};
      else         m_pc = m_pc + PC_W'(1);
      m_ir    = fetched;
      m_valid = !(tj || tp);
      m_tag   = tj ? (we ? "R8" : "R6") : tp ? "R7" : (jr || we) ? "R9" : "R4";
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      m_pc = '0; m_ir = '0; m_valid = 1'b0; m_tag = "R3";
      repeat (3) @(negedge clk);
      // R3: reset state
      chk(imem_addr == 0, "R3", "reset address", imem_addr, 0);
      chk(insn_valid_o == 1'b0, "R3", "reset valid", insn_valid_o, 0);
      chk(phase_o == 4'b0001, "R1", "reset phase", phase_o, 1);
      rst_n = 1'b1;
      // R3/R9: jump request during the empty first slot is ignored
      run_cycle(1'b1, 11'h100, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b1);   // R3 then R5: word 0 executes
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      // R6: jump near top of address space
      run_cycle(1'b1, 11'h7FE, 1'b0, 8'h00, 1'b0);
      // R9: requests during the bubble are ignored
      run_cycle(1'b1, 11'h050, 1'b1, 8'h11, 1'b1);
      // R4: wrap 7FF -> 000
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      // R7: low-byte write keeps upper bits
      run_cycle(1'b1, 11'h5A0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b1, 8'h3C, 1'b1);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      // R8: both requests, jump wins
      run_cycle(1'b1, 11'h222, 1'b1, 8'hEE, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      run_cycle(1'b0, '0, 1'b0, 8'h00, 1'b0);
      // random tail
      for (int c = 0; c < 120; c++) begin
         run_cycle(($urandom % 4) == 0, PC_W'($urandom),
                   ($urandom % 5) == 0, PCL_W'($urandom), 1'($urandom));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule